// File: doc/BRIEF.md
# Microwire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM. It holds 16-bit words and talks to a host over four wires: chip select, serial clock, serial data in and serial data out. Its logic runs entirely on the serial clock. On each rising edge while chip select is high, it samples one bit of the incoming stream. It decodes a start bit, a two-bit opcode and a word address, then runs the command. The commands are read, write, erase of one word, erase of all words, write of one value to all words, and enabling or disabling programming.

Programming does not take real time. Instead it keeps the device busy for a configurable number of serial clock edges. A host that drops chip select and raises it again can poll data out: it reads low while busy and high once the device is ready. The parameter `ADDR_W` selects 6-bit addressing (64 words) or 8-bit addressing (256 words). The word array resets to the erased value, so every bit is 1.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, programming is disabled, every word reads 0xFFFF, the decoder waits for a start bit, and data out is 1 while chip select is high and no command is in progress.
- R2: A command starts with a 1 sampled on a rising serial clock edge while chip select is high. Zeros sampled before it are ignored. The start bit is followed by a 2-bit opcode and `ADDR_W` address bits, all most significant bit first.
- R3: Opcode 2'b10 (read) drives data out to 0 from the edge that samples the last address bit. Each of the next 16 rising edges then launches the addressed word, bit 15 first.
- R4: Opcode 2'b01 (write) takes 16 further data bits, most significant first, and stores them at the address.
- R5: Opcode 2'b11 (erase) sets the addressed word to 0xFFFF.
- R6: Under opcode 2'b00, the two most significant address bits select the action: 2'b11 enables programming, 2'b00 disables it, 2'b10 sets all words to 0xFFFF, and 2'b01 writes the 16 data bits that follow into every word. The remaining address bits have no effect.
- R7: Write, erase, erase-all and write-all change no word and start no busy period unless programming is enabled. After a disable command they are blocked again.
- R8: An accepted programming command keeps the device busy for `PROG_CYCLES` rising edges, counted from the edge that samples its final bit. When chip select is raised again, data out reads 0 while busy and 1 once ready.
- R9: A start bit presented while the device is busy is ignored, and the decoder keeps waiting.
- R10: A rising edge that samples chip select low abandons any partly received command. The decoder then waits for a start bit, and no word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial clock; all state advances on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Chip select, active high |
| dataIn | input | 1 | Serial command, address and data input |
| dataOut | output | 1 | Serial read data, or ready status when idle |

## Verification
The bench goes after the following corner cases, and what a wrong design would do in each:
- **Read framing.** A design that forgets the dummy zero, or launches data one edge late, returns a word shifted by one bit.
- **Write protection.** A design that ignores the enable latch would overwrite words while protected, or report busy after a rejected command.
- **Extended opcodes.** The low address bits are filled with noise. A decoder that looks at them, or mixes up erase-all with write-all, leaves the wrong contents in words spread across the array.
- **Busy, start bit and abort.** The length of the busy window is measured exactly. Start bits are sent during that window, and commands are cut off by dropping chip select. A design that accepts the start bit would erase word 0. A design that runs the cut-off command would corrupt the target word.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  localparam int DATA_W = 16;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_WDS  = 2'b00;
  localparam logic [1:0] EXT_WRAL = 2'b01;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_WEN  = 2'b11;

  typedef struct packed {
    logic loadRead;
    logic shiftRead;
    logic shiftData;
    logic wrWord;
    logic eraseWord;
    logic wrAll;
    logic eraseAll;
    logic setWen;
    logic clrWen;
  } mwStrobe_t;

endpackage

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sck,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              dataIn,
  input  logic              busy,
  output mwStrobe_t         strb,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              readPhase,
  output logic              idlePhase
);

  localparam int CMD_LEN = ADDR_W + 2;
  localparam int MAX_LEN = (CMD_LEN > DATA_W) ? CMD_LEN : DATA_W;
  localparam int CNT_W   = $clog2(MAX_LEN);

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_DONE} state_t;

  state_t             state, nextState;
  logic [CNT_W-1:0]   bitCnt;
  logic [CMD_LEN-2:0] cmdReg;
  logic [CMD_LEN-1:0] cmdFull;
  logic [ADDR_W-1:0]  addrReg;
  logic               fillAll;
  logic [1:0]         opCode, extCode;
  logic               cmdDone, dataDone;

  assign cmdFull  = {cmdReg, dataIn};
  assign opCode   = cmdFull[CMD_LEN-1 -: 2];
  assign extCode  = cmdFull[ADDR_W-1 -: 2];
  assign cmdDone  = (state == ST_CMD)  && (bitCnt == CNT_W'(CMD_LEN - 1));
  assign dataDone = (state == ST_DATA) && (bitCnt == CNT_W'(DATA_W - 1));

  always_comb begin
    strb      = '0;
    nextState = state;
    wordAddr  = (state == ST_CMD) ? cmdFull[ADDR_W-1:0] : addrReg;
    case (state)
      ST_IDLE: if (dataIn && !busy) nextState = ST_CMD;
      ST_CMD: begin
        if (cmdDone) begin
          nextState = ST_DONE;
          case (opCode)
            OP_READ: begin
              strb.loadRead = 1'b1;
              nextState     = ST_READ;
            end
            OP_WRITE: nextState = ST_DATA;
            OP_ERASE: strb.eraseWord = 1'b1;
            default: begin
              case (extCode)
                EXT_WEN:  strb.setWen   = 1'b1;
                EXT_WDS:  strb.clrWen   = 1'b1;
                EXT_ERAL: strb.eraseAll = 1'b1;
                default:  nextState     = ST_DATA;
              endcase
            end
          endcase
        end
      end
      ST_DATA: begin
        strb.shiftData = 1'b1;
        if (dataDone) begin
          strb.wrAll  = fillAll;
          strb.wrWord = !fillAll;
          nextState   = ST_DONE;
        end
      end
      ST_READ: strb.shiftRead = 1'b1;
      default: ;
    endcase
    if (!chipSel) begin
      strb      = '0;
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      cmdReg  <= '0;
      addrReg <= '0;
      fillAll <= 1'b0;
    end else begin
      state  <= nextState;
      bitCnt <= (nextState != state) ? '0 : bitCnt + 1'b1;
      if (state == ST_CMD) cmdReg <= {cmdReg[CMD_LEN-3:0], dataIn};
      if (cmdDone) begin
        addrReg <= cmdFull[ADDR_W-1:0];
        fillAll <= (opCode == OP_EXT);
      end
    end
  end

  assign readPhase = (state == ST_READ);
  assign idlePhase = (state == ST_IDLE);

  AST_CS_ABORT: assert property (@(posedge sck) disable iff (!rstN)
    !chipSel |=> state == ST_IDLE); // R10
  AST_BUSY_HOLDS_IDLE: assert property (@(posedge sck) disable iff (!rstN)
    (state == ST_IDLE && busy) |=> state == ST_IDLE); // R9
  AST_ONE_ACTION: assert property (@(posedge sck) disable iff (!rstN)
    $countones({strb.loadRead, strb.wrWord, strb.eraseWord, strb.wrAll,
                strb.eraseAll, strb.setWen, strb.clrWen}) <= 1); // R6

endmodule

// File: rtl/mw_eeprom_dp.sv
module mw_eeprom_dp
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 20
) (
  input  logic              sck,
  input  logic              rstN,
  input  logic              dataIn,
  input  mwStrobe_t         strb,
  input  logic [ADDR_W-1:0] wordAddr,
  output logic              busy,
  output logic              readBit
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-2:0] dataReg;
  logic [DATA_W:0]   rdShift;
  logic [CNT_W-1:0]  busyCnt;
  logic              wen;
  logic              progReq, progGo, eraseOp, allOp;
  logic [DATA_W-1:0] fillVal;

  assign progReq = strb.wrWord | strb.eraseWord | strb.wrAll | strb.eraseAll;
  assign progGo  = progReq & wen;
  assign eraseOp = strb.eraseWord | strb.eraseAll;
  assign allOp   = strb.wrAll | strb.eraseAll;
  assign fillVal = eraseOp ? '1 : {dataReg, dataIn};

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else if (progGo) begin
      for (int w = 0; w < WORDS; w++)
        if (allOp || (w == int'(wordAddr))) mem[w] <= fillVal;
    end
  end

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      wen     <= 1'b0;
      busyCnt <= '0;
      dataReg <= '0;
      rdShift <= '0;
    end else begin
      if (strb.setWen) wen <= 1'b1;
      else if (strb.clrWen) wen <= 1'b0;
      if (progGo) busyCnt <= CNT_W'(PROG_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      if (strb.shiftData) dataReg <= {dataReg[DATA_W-3:0], dataIn};
      if (strb.loadRead) rdShift <= {1'b0, mem[wordAddr]};
      else if (strb.shiftRead) rdShift <= {rdShift[DATA_W-1:0], 1'b0};
    end
  end

  assign busy    = (busyCnt != '0);
  assign readBit = rdShift[DATA_W];

  AST_PROTECTED_NO_BUSY: assert property (@(posedge sck) disable iff (!rstN)
    (!wen && !busy && progReq) |=> !busy); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge sck) disable iff (!rstN)
    (wen && progReq) |=> busy); // R8
  AST_READ_DUMMY: assert property (@(posedge sck) disable iff (!rstN)
    strb.loadRead |=> !readBit); // R3

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 20
) (
  input  logic sck,
  input  logic rstN,
  input  logic chipSel,
  input  logic dataIn,
  output logic dataOut
);

  mwStrobe_t         strb;
  logic [ADDR_W-1:0] wordAddr;
  logic              busy, readBit, readPhase, idlePhase;

  mw_eeprom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .sck(sck), .rstN(rstN), .chipSel(chipSel), .dataIn(dataIn), .busy(busy),
    .strb(strb), .wordAddr(wordAddr), .readPhase(readPhase), .idlePhase(idlePhase)
  );

  mw_eeprom_dp #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .sck(sck), .rstN(rstN), .dataIn(dataIn), .strb(strb), .wordAddr(wordAddr),
    .busy(busy), .readBit(readBit)
  );

  assign dataOut = chipSel & (readPhase ? readBit : (idlePhase & ~busy));

endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 6;
  localparam int PROG       = 20;
  localparam int NVEC       = 6;
  // {address, data}: write then read back
  localparam logic [23:0] VECS [NVEC] = '{
    24'h00_0000, 24'h3F_FFFF, 24'h15_A5A5, 24'h2A_8001, 24'h07_1234, 24'h00_7FFE
  };

  logic sck = 1'b0, rstN = 1'b0, cs = 1'b0, di = 1'b0;
  logic dout;
  int   errors = 0, checks = 0;
  bit   finished = 1'b0;

  mw_eeprom #(.ADDR_W(AW), .PROG_CYCLES(PROG)) dut (
    .sck(sck), .rstN(rstN), .chipSel(cs), .dataIn(di), .dataOut(dout)
  );

  always #(CLK_PERIOD/2) sck = ~sck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shiftOut(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge sck); cs = 1'b1; di = v[i];
    end
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [AW-1:0] a);
    shiftOut({23'd0, 1'b1, op, a}, 3 + AW);
  endtask

  task automatic endCmd();
    @(negedge sck); cs = 1'b0; di = 1'b0;
    @(negedge sck); cs = 1'b1; #1;
  endtask

  // number of extra edges waited until ready (0 if ready at once)
  task automatic waitReady(output int waits);
    waits = 0;
    while (dout !== 1'b1 && waits < 5000) begin
      @(negedge sck); waits++;
    end
  endtask

  task automatic readWord(input logic [AW-1:0] a, output logic dummy, output logic [15:0] v);
    sendCmd(2'b10, a);
    @(negedge sck); dummy = dout;
    for (int i = 15; i >= 0; i--) begin
      @(negedge sck); v[i] = dout;
    end
    endCmd();
  endtask

  task automatic writeWord(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] v);
    sendCmd(op, a);
    shiftOut({16'd0, v}, 16);
    endCmd();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic dummy;
    logic [15:0] v;
    int w;
    repeat (3) @(negedge sck);
    rstN = 1'b1;
    @(negedge sck); cs = 1'b1; #1;
    check("R1 idle ready", dout, 1);
    readWord(6'd3, dummy, v);
    check("R1 erased after reset", v, 16'hFFFF);
    check("R3 dummy zero", dummy, 0);

    // protected at reset: write ignored
    writeWord(2'b01, 6'd2, 16'h1234);
    waitReady(w);
    check("R7 no busy when protected", w, 0);
    readWord(6'd2, dummy, v);
    check("R7 word unchanged", v, 16'hFFFF);

    // enable, low address bits noise
    sendCmd(2'b00, 6'b11_0101); endCmd();
    waitReady(w);
    check("R6 enable not busy", w, 0);

    for (int k = 0; k < NVEC; k++) begin
      writeWord(2'b01, VECS[k][21:16], VECS[k][15:0]);
      waitReady(w);
      check("R8 busy length", w, PROG - 1);
      readWord(VECS[k][21:16], dummy, v);
      check("R3 dummy zero", dummy, 0);
      check("R4 write readback", v, VECS[k][15:0]);
    end

    // erase single word
    sendCmd(2'b11, 6'd21); endCmd();
    waitReady(w);
    check("R8 erase busy", w, PROG - 1);
    readWord(6'd21, dummy, v);
    check("R5 erased word", v, 16'hFFFF);
    readWord(6'd42, dummy, v);
    check("R5 neighbour kept", v, 16'h8001);

    // write all
    writeWord(2'b00, 6'b01_1001, 16'h5A5A);
    waitReady(w);
    check("R8 write-all busy", w, PROG - 1);
    readWord(6'd0, dummy, v);  check("R6 write-all w0", v, 16'h5A5A);
    readWord(6'd17, dummy, v); check("R6 write-all w17", v, 16'h5A5A);
    readWord(6'd63, dummy, v); check("R6 write-all w63", v, 16'h5A5A);

    // erase all
    sendCmd(2'b00, 6'b10_0110); endCmd();
    waitReady(w);
    check("R8 erase-all busy", w, PROG - 1);
    readWord(6'd9, dummy, v);  check("R6 erase-all w9", v, 16'hFFFF);
    readWord(6'd40, dummy, v); check("R6 erase-all w40", v, 16'hFFFF);

    // start bits during busy are ignored (would otherwise erase word 0)
    writeWord(2'b01, 6'd0, 16'h0F0F);
    for (int i = 0; i < 3; i++) begin
      @(negedge sck); di = 1'b1;
    end
    @(negedge sck); di = 1'b0; #1;
    waitReady(w);
    check("R9 busy unaffected", w + 4, PROG - 1);
    readWord(6'd0, dummy, v);
    check("R9 word0 intact", v, 16'h0F0F);

    // abort mid-data
    sendCmd(2'b01, 6'd5);
    shiftOut(32'h00AA, 8);
    endCmd();
    waitReady(w);
    check("R10 abort no busy", w, 0);
    readWord(6'd5, dummy, v);
    check("R10 word unchanged", v, 16'hFFFF);

    // leading zeros before the start bit
    shiftOut(32'd0, 5);
    readWord(6'd0, dummy, v);
    check("R2 leading zeros", v, 16'h0F0F);

    // disable, then programming blocked again
    sendCmd(2'b00, 6'b00_1010); endCmd();
    writeWord(2'b01, 6'd4, 16'h4444);
    waitReady(w);
    check("R7 disabled no busy", w, 0);
    readWord(6'd4, dummy, v);
    check("R7 disabled write", v, 16'hFFFF);
    sendCmd(2'b11, 6'd0); endCmd();
    sendCmd(2'b00, 6'b10_0000); endCmd();
    waitReady(w);
    check("R7 disabled erase no busy", w, 0);
    readWord(6'd0, dummy, v);
    check("R7 disabled erase", v, 16'h0F0F);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule